// File: doc/BRIEF.md
# I2S Transmit Serializer

This block turns 32-bit sample words taken from a show-ahead transmit FIFO into a two-channel I2S serial stream. It always acts as clock master. It derives the bit clock from the master clock through an 8-bit ratio value, so that one bit clock period lasts 2*(ratio+2) master cycles. A 6-bit resolution value sets how many low-order bits of each word go out. It also sets the slot length, so a frame lasts twice that many bit clocks. With the master clock at 256 times the sample rate, ratio 0 with resolution 32 and ratio 2 with resolution 16 each give exactly one frame per sample period.

Every frame takes two FIFO words, the left one first. When transmit is switched on, the block sends a full frame of zeros, starting on the left channel, before any queued word. If the FIFO has no word when a slot begins, that slot carries zeros. When transmit is switched off, the current frame runs to its end, and then the bit clock, word select and data settle low.

Top module: `i2s_tx_ser`

## Requirements
- R1: After reset, sck, ws, sd and fifo_pop are all low.
- R2: While transmitting, sck has a period of exactly 2*(ratio+2) clk cycles, high and low halves of ratio+2 cycles each.
- R3: Each channel slot lasts res bit clocks, where res is the resolution input, except that 0 or any value above 32 means 32. ws is low for the left slot and high for the right slot. ratio and resolution are captured at the start of every frame.
- R4: ws and sd change only on falling edges of sck. Each word goes out MSB first. Its first bit is sent one bit clock after the ws transition, and its LSB is sent in the bit period in which ws changes for the next slot.
- R5: Only bits res-1..0 of a FIFO word are sent, so higher bits have no effect on sd.
- R6: Each frame pops up to two words, left then right. fifo_pop is a one-cycle pulse in the clk cycle right after the sck falling edge that opens a slot. The word is taken from fifo_data while fifo_empty is low.
- R7: When enable rises from idle, the first frame is all zeros, begins with the left slot, and pops no word.
- R8: If fifo_empty is high when a slot opens, that slot sends all zeros and no pop is issued.
- R9: When enable goes low, the block finishes the frame in progress, including the right LSB. After that, sck, ws and sd stay low, no further pop occurs, and the number of slots sent is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Transmit on |
| ratio | input | 8 | Bit clock divider value |
| resolution | input | 6 | Bits sent per slot |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_data | input | 32 | Word at the FIFO head |
| fifo_pop | output | 1 | Consume the FIFO head word |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select, low for left |
| sd | output | 1 | Serial data |

## Verification
The bench builds the block with its default widths: 32-bit words, an 8-bit ratio and a 6-bit resolution. It runs ratios 0 to 3 against resolutions 32, 16, 24 and 0. These cover both master-clock presets, a slot width that is not a power of two, and the rule that treats an out-of-range width as 32. Words carry nonzero upper bits to show the masking. Runs outlast their data to reach underrun slots, and a short enable pulse shows a run that stops inside its leading zero frame.

// File: rtl/i2s_tx_ser.sv
module i2s_tx_ser #(
  parameter int DATA_W  = 32,
  parameter int RATIO_W = 8,
  parameter int RES_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [RES_W-1:0]   resolution,
  input  logic               fifo_empty,
  input  logic [DATA_W-1:0]  fifo_data,
  output logic               fifo_pop,
  output logic               sck,
  output logic               ws,
  output logic               sd
);
  localparam int POS_W = $clog2(DATA_W + 1);
  localparam int CNT_W = RATIO_W + 1;

  logic               run, tail, zf, ch, pend;
  logic [POS_W-1:0]   pos, res_q;
  logic [RATIO_W-1:0] ratio_q;
  logic [CNT_W-1:0]   cnt;
  logic [DATA_W-1:0]  cur;
  logic               sck_q, ws_q, sd_q, pop_q;

  logic [POS_W-1:0]  res_eff, res_sel, pos_nx, idx;
  logic              tick, fe, slot_end, frame_end, ch_nx, zf_nx, take, bit_nx;
  logic [DATA_W-1:0] word_nx, src, shifted;

  assign res_eff   = (resolution == '0 || int'(resolution) > DATA_W) ? POS_W'(DATA_W) : POS_W'(resolution);
  assign tick      = (cnt == ({1'b0, ratio_q} + CNT_W'(1)));
  assign fe        = tick && sck_q;
  assign slot_end  = (pos == res_q - POS_W'(1));
  assign frame_end = slot_end && ch;
  assign pos_nx    = slot_end ? '0 : pos + POS_W'(1);
  assign ch_nx     = slot_end ? ~ch : ch;
  assign zf_nx     = frame_end ? 1'b0 : zf;
  assign take      = slot_end && !zf_nx && !fifo_empty;
  assign word_nx   = take ? fifo_data : '0;
  assign res_sel   = frame_end ? res_eff : res_q;
  assign src       = slot_end ? word_nx : cur;
  assign idx       = res_sel - POS_W'(1) - pos_nx;
  assign shifted   = src >> idx;
  assign bit_nx    = shifted[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; tail <= 1'b0; zf <= 1'b0; ch <= 1'b0; pend <= 1'b0;
      pos <= '0; res_q <= POS_W'(DATA_W); ratio_q <= '0; cnt <= '0; cur <= '0;
      sck_q <= 1'b0; ws_q <= 1'b0; sd_q <= 1'b0; pop_q <= 1'b0;
    end else begin
      pop_q <= 1'b0;
      if (!run && !tail) begin
        if (enable) begin
          run <= 1'b1; zf <= 1'b1; ch <= 1'b0; pos <= '0; pend <= 1'b0;
          res_q <= res_eff; ratio_q <= ratio; cnt <= '0; cur <= '0;
          sck_q <= 1'b0; ws_q <= 1'b0; sd_q <= 1'b0;
        end
      end else begin
        if (tick) begin
          cnt   <= '0;
          sck_q <= ~sck_q;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
        if (fe) begin
          if (tail) begin
            tail <= 1'b0;
            sd_q <= 1'b0;
          end else if (frame_end && !enable) begin
            run  <= 1'b0;
            tail <= 1'b1;
            ws_q <= 1'b0;
            sd_q <= pend;
          end else begin
            pos  <= pos_nx;
            ch   <= ch_nx;
            ws_q <= ch_nx;
            sd_q <= pend;
            pend <= bit_nx;
            if (slot_end) begin
              cur   <= word_nx;
              pop_q <= take;
            end
            if (frame_end) begin
              zf      <= zf_nx;
              res_q   <= res_eff;
              ratio_q <= ratio;
            end
          end
        end
      end
    end
  end

  assign sck      = sck_q;
  assign ws       = ws_q;
  assign sd       = sd_q;
  assign fifo_pop = pop_q;
endmodule

// File: rtl/i2s_tx_ser_chk.sv
module i2s_tx_ser_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic ws,
  input logic sd,
  input logic fifo_pop,
  input logic fifo_empty,
  input logic run,
  input logic tail,
  input logic zf
);
  assert_ws_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws) |-> $fell(sck));
  assert_sd_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd) |-> $fell(sck));
  assert_pop_after_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> $fell(sck));
  assert_pop_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !fifo_pop);
  assert_no_pop_zero_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (zf && run) |-> !fifo_pop);
  assert_idle_parked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !tail) |-> (!sck && !ws && !sd));
  assert_sck_only_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sck) |-> $past(run || tail));
  assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_pop) |-> $past(!fifo_empty));
endmodule

bind i2s_tx_ser i2s_tx_ser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .ws(ws), .sd(sd),
  .fifo_pop(fifo_pop), .fifo_empty(fifo_empty),
  .run(run), .tail(tail), .zf(zf)
);

// File: tb/test_i2s_tx_ser.sv
module test_i2s_tx_ser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  ratio = 8'd0;
  logic [5:0]  resolution = 6'd32;
  logic        fifo_empty = 1'b1;
  logic [31:0] fifo_data = '0;
  logic        fifo_pop, sck, ws, sd;

  i2s_tx_ser i_i2s_tx_ser (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ratio(ratio), .resolution(resolution),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .sck(sck), .ws(ws), .sd(sd)
  );

  always #2 clk = ~clk;

  int compared = 0, mismatched = 0;
  logic [31:0] fq[$];
  logic [32:0] eq[$];
  int pops = 0, pops0 = 0, rx_words = 0, res_cfg = 32, ratio_cfg = 0;
  bit fresh = 1, first_word = 1;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic refresh();
    fifo_empty = (fq.size() == 0);
    fifo_data  = (fq.size() == 0) ? 32'h0 : fq[0];
  endtask

  always @(posedge clk) begin
    if (fifo_pop) begin
      pops++;
      if (fq.size() != 0) void'(fq.pop_front());
      refresh();
    end
  end

  function automatic logic [31:0] mask_of(int r);
    return (r >= 32) ? 32'hFFFF_FFFF : ((32'h1 << r) - 32'h1);
  endfunction

  logic [31:0] acc = '0;
  int nb = 0, negs = 0, last_rise = 0;
  logic sck_p = 1'b0, ws_p = 1'b0;

  task automatic emit(logic chn);
    logic [31:0] got;
    logic [32:0] e;
    got = acc & mask_of(res_cfg);
    rx_words++;
    if (first_word) begin
      chk(pops - pops0 == 0, "R7", "pop during zero frame", pops - pops0, 0);
      chk(chn == 1'b0, "R7", "zero frame starts left", chn, 0);
      first_word = 0;
    end else begin
      chk(nb == res_cfg, "R3", "bits per slot", nb, res_cfg);
    end
    if (eq.size() != 0) begin
      e = eq.pop_front();
      chk(chn == e[32], "R3", "slot channel", chn, e[32]);
      chk(got == e[31:0], "R4 R5", "slot word", got, e[31:0]);
    end else begin
      chk(got == 32'h0, "R8", "underrun slot", got, 0);
    end
  endtask

  always @(negedge clk) begin
    negs++;
    if (rst_n && sck && !sck_p) begin
      if (!fresh)
        chk(negs - last_rise == 2 * (ratio_cfg + 2), "R2", "sck period", negs - last_rise, 2 * (ratio_cfg + 2));
      fresh = 0;
      last_rise = negs;
      acc = {acc[30:0], sd};
      nb++;
      if (ws != ws_p) begin
        emit(ws_p);
        acc = '0;
        nb = 0;
      end
      ws_p = ws;
    end
    sck_p = sck;
  end

  task automatic wait_idle();
    int z = 0;
    while (z < 4 * (ratio_cfg + 2) + 8) begin
      @(negedge clk);
      if (sck) z = 0; else z++;
    end
  endtask

  task automatic start_cfg(int r, int s);
    ratio = 8'(r);
    resolution = 6'(s);
    ratio_cfg = r;
    res_cfg = (s == 0 || s > 32) ? 32 : s;
    fresh = 1;
    first_word = 1;
    pops0 = pops;
    rx_words = 0;
    eq.push_back({1'b0, 32'h0});
    eq.push_back({1'b1, 32'h0});
  endtask

  task automatic run_case(int r, int s, int n, int extra, logic [31:0] seed);
    @(negedge clk);
    start_cfg(r, s);
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      w = seed ^ (32'(i) * 32'h9E37_79B9) ^ 32'hF0F0_0000;
      fq.push_back(w);
      eq.push_back({1'(i % 2), w & mask_of(res_cfg)});
    end
    refresh();
    enable = 1'b1;
    while (eq.size() != 0) @(negedge clk);
    repeat (extra * 4 * res_cfg * (r + 2)) @(negedge clk);
    enable = 1'b0;
    wait_idle();
    chk(pops - pops0 == n, "R6", "pops per run", pops - pops0, n);
    chk(rx_words % 2 == 0, "R9", "even slot count", rx_words, 0);
    chk(!sck && !ws && !sd, "R9", "parked low", {sck, ws, sd}, 0);
    chk(!fifo_pop, "R9", "no pop when parked", fifo_pop, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!sck && !ws && !sd && !fifo_pop, "R1", "reset outputs", {sck, ws, sd, fifo_pop}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_case(0, 32, 8, 0, 32'h1234_5678);
    run_case(2, 16, 6, 1, 32'hCAFE_BEEF);
    run_case(1, 24, 4, 2, 32'h0BAD_F00D);
    run_case(3, 0, 4, 0, 32'h5555_AAAA);
    // short enable pulse: stops inside zero frame
    @(negedge clk);
    start_cfg(0, 16);
    fq.push_back(32'hFFFF_FFFF);
    fq.push_back(32'hFFFF_FFFF);
    refresh();
    enable = 1'b1;
    repeat (3) @(negedge clk);
    enable = 1'b0;
    wait_idle();
    chk(rx_words == 2, "R9", "slots after short enable", rx_words, 2);
    chk(pops - pops0 == 0, "R7", "no pop after short enable", pops - pops0, 0);
    chk(eq.size() == 0, "R7", "zero frame delivered", eq.size(), 0);
    fq.delete();
    refresh();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule